// File: doc/BRIEF.md
# SD/MMC Host Status and Interrupt Logic

This block holds the event status word and the interrupt-enable word of an SD/MMC host controller. One-cycle event pulses from the command engine, the data engine, the buffer logic and card detection are caught in sticky status bits. Each sticky bit stays set until software writes a one to its position. A few buffer and clock indications are shown as live levels rather than being latched. A two-bit write-CRC status code is captured next to the sticky flags.

The enable word selects which conditions drive the single level interrupt output. A separate error output is the OR of the error flags. Software reaches both words through a small register port. Address 0 is the status word and address 1 is the enable word. Reads are combinational. Writes take effect at the next clock edge.

Top module: `sdmmc_irq_ctrl`

## Requirements
- R1: After reset every sticky status bit, the write-CRC code field and every enable bit read as 0.
- R2: A pulse on `evt_pulse[i]` sets status bit i at the next edge, and the bit stays set. This applies to the sticky positions 31 (card inserted), 30 (card removed), 29..26 (buffer Y-empty, X-empty, Y-full, X-full), 25 (underrun), 24 (overflow), 14 (SDIO interrupt), 13 (command response ended), 12 (write done), 11 (read done / transfer done), 5 (response CRC error), 3 (read CRC error), 2 (write CRC error), 1 (response timeout) and 0 (read timeout).
- R3: Writing the status word clears each sticky bit written as 1 and leaves bits written as 0 unchanged. Writing ones to bits 10..6 or to unused positions changes nothing.
- R4: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is set after the edge.
- R5: Status bits 8 (card clock running), 7 (buffer read-ready) and 6 (buffer write-ready) always show the live inputs `card_clk_on`, `buf_rd_rdy` and `buf_wr_rdy`.
- R6: Status bits [10:9] load `wcrc_code` whenever bit 2 is set by an event. They clear to 0 when bit 2 is cleared by a write with no event in that cycle. Code value 2 means the card sent no CRC token.
- R7: `err_any` is high exactly when any of status bits 5, 3, 2, 1 or 0 is set.
- R8: Writing address 1 stores bits 0..4 and 12..18 of the write data into the enable word. All other enable bits read 0. The enable word changes on no other cycle.
- R9: `irq` is the OR of the following pairs:
  - enable 0 with status 11
  - enable 1 with status 12
  - enable 2 with status 13
  - enable 3 with live write-ready
  - enable 4 with live read-ready
  - enable 13 with status 14
  - enable 14 with status 30
  - enable 15 with status 31
- R10: Enable bits 12 (DAT0) and 16..18 (wake for removal, insertion and SDIO) are only stored and never affect `irq`.
- R11: Event pulses on positions that are not sticky (23..15, 10..6, 4) leave the status word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_wr | input | 1 | Write when high with `reg_sel` |
| reg_addr | input | 1 | 0 = status word, 1 = enable word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| evt_pulse | input | 32 | Event pulses, one per status position |
| wcrc_code | input | 2 | Write-CRC status code from the data path |
| buf_rd_rdy | input | 1 | Live buffer read-ready level |
| buf_wr_rdy | input | 1 | Live buffer write-ready level |
| card_clk_on | input | 1 | Live card clock running level |
| irq | output | 1 | Level interrupt |
| err_any | output | 1 | Aggregate error flag |

## Verification
The hardest case to reach is an event racing a clearing write on the same bit in the same cycle. The same race on bit 2 also decides whether the code field reloads or clears. The stimulus aligns an event pulse with a write-one-to-clear on chosen bits in one cycle. It then repeats the clear alone, so both outcomes are seen. A behavioural model in the bench follows every cycle and compares the read data, `irq` and `err_any`. Stored-only enable bits are exercised with every interrupt source pending, so any leak into `irq` is visible.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int unsigned REG_W = 32;

  // status positions that other logic decodes
  localparam int unsigned S_INS     = 31;
  localparam int unsigned S_REM     = 30;
  localparam int unsigned S_SDIO    = 14;
  localparam int unsigned S_CMDEND  = 13;
  localparam int unsigned S_WRDONE  = 12;
  localparam int unsigned S_RDDONE  = 11;
  localparam int unsigned S_CODE_LO = 9;
  localparam int unsigned S_CLKRUN  = 8;
  localparam int unsigned S_RDRDY   = 7;
  localparam int unsigned S_WRRDY   = 6;
  localparam int unsigned S_WCRC    = 2;

  localparam logic [REG_W-1:0] STICKY_MASK = 32'hFF00_782F;
  localparam logic [REG_W-1:0] ERR_MASK    = 32'h0000_002F;
  localparam logic [REG_W-1:0] EN_MASK     = 32'h0007_F01F;
  localparam logic [REG_W-1:0] EN_IRQ_MASK = 32'h0000_E01F;

  // interrupt source table: status position and its enable position
  localparam int unsigned N_SRC = 8;
  localparam int unsigned SRC_POS [N_SRC] = '{S_RDDONE, S_WRDONE, S_CMDEND, S_WRRDY,
                                              S_RDRDY, S_SDIO, S_REM, S_INS};
  localparam int unsigned EN_POS  [N_SRC] = '{0, 1, 2, 3, 4, 13, 14, 15};

  function automatic logic [REG_W-1:0] sticky_next(input logic [REG_W-1:0] cur,
                                                   input logic [REG_W-1:0] set,
                                                   input logic [REG_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic logic [1:0] code_next(input logic [1:0] cur, input logic [1:0] din,
                                           input logic hit, input logic clr);
    if (hit)      return din;
    else if (clr) return 2'd0;
    else          return cur;
  endfunction
endpackage

// File: rtl/sdirq_status.sv
module sdirq_status
  import sdirq_pkg::*;
#(
  parameter logic [REG_W-1:0] KEEP = STICKY_MASK
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] set_vec,
  input  logic [REG_W-1:0] clr_vec,
  input  logic [1:0]       code_in,
  output logic [REG_W-1:0] sticky_q,
  output logic [1:0]       code_q
);
  logic [REG_W-1:0] set_m, clr_m, clr_only;
  logic             code_hit, code_clr;

  assign set_m    = set_vec & KEEP;
  assign clr_m    = clr_vec & KEEP;
  assign clr_only = clr_m & ~set_m;
  assign code_hit = set_m[S_WCRC];
  assign code_clr = clr_m[S_WCRC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sticky_q <= '0;
      code_q   <= 2'd0;
    end else begin
      sticky_q <= sticky_next(sticky_q, set_m, clr_m) & KEEP;
      code_q   <= code_next(code_q, code_in, code_hit, code_clr);
    end
  end

  p_set_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_m) |=> ((sticky_q & $past(set_m)) == $past(set_m)));
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_only) |=> ((sticky_q & $past(clr_only)) == '0));
  p_code_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> (code_q == $past(code_in)));
  p_no_stray_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((sticky_q & ~KEEP) == '0));
endmodule

// File: rtl/sdirq_enable.sv
module sdirq_enable
  import sdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] en_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en_q <= '0;
    else if (wr_en) en_q <= wdata & EN_MASK;
  end

  p_en_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q));
endmodule

// File: rtl/sdirq_irq.sv
module sdirq_irq
  import sdirq_pkg::*;
(
  input  logic [REG_W-1:0] view,
  input  logic [REG_W-1:0] en,
  output logic             irq
);
  logic [N_SRC-1:0] term;

  always_comb begin
    for (int k = 0; k < N_SRC; k++) term[k] = view[SRC_POS[k]] & en[EN_POS[k]];
  end

  assign irq = |term;
endmodule

// File: rtl/sdmmc_irq_ctrl.sv
module sdmmc_irq_ctrl
  import sdirq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic [31:0] evt_pulse,
  input  logic [1:0]  wcrc_code,
  input  logic        buf_rd_rdy,
  input  logic        buf_wr_rdy,
  input  logic        card_clk_on,
  output logic        irq,
  output logic        err_any
);
  logic             wr_status, wr_enable;
  logic [REG_W-1:0] clr_vec, sticky_q, en_q, live_vec, code_vec, status_view;
  logic [1:0]       code_q;

  assign wr_status = reg_sel & reg_wr & ~reg_addr;
  assign wr_enable = reg_sel & reg_wr &  reg_addr;
  assign clr_vec   = wr_status ? reg_wdata : '0;

  sdirq_status #(.KEEP(STICKY_MASK)) u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vec  (evt_pulse),
    .clr_vec  (clr_vec),
    .code_in  (wcrc_code),
    .sticky_q (sticky_q),
    .code_q   (code_q)
  );

  sdirq_enable u_enable (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_enable),
    .wdata (reg_wdata),
    .en_q  (en_q)
  );

  always_comb begin
    live_vec           = '0;
    live_vec[S_CLKRUN] = card_clk_on;
    live_vec[S_RDRDY]  = buf_rd_rdy;
    live_vec[S_WRRDY]  = buf_wr_rdy;
    code_vec           = '0;
    code_vec[S_CODE_LO +: 2] = code_q;
  end

  assign status_view = sticky_q | code_vec | live_vec;

  sdirq_irq u_irq (
    .view (status_view),
    .en   (en_q),
    .irq  (irq)
  );

  assign err_any   = |(sticky_q & ERR_MASK);
  assign reg_rdata = reg_addr ? en_q : status_view;

  p_err_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_any) |-> $past(|(evt_pulse & ERR_MASK)));
  p_irq_needs_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((en_q & EN_IRQ_MASK) != '0));
  p_stored_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_q & EN_IRQ_MASK) == '0) |-> !irq);
endmodule

// File: tb/tb_sdmmc_irq_ctrl.sv
module tb_sdmmc_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0, evt_pulse = '0;
  logic [1:0]  wcrc_code = 2'd0;
  logic        buf_rd_rdy = 1'b0, buf_wr_rdy = 1'b0, card_clk_on = 1'b0;
  logic [31:0] reg_rdata;
  logic        irq, err_any;

  int n_checks = 0, n_fail = 0;
  string cur_tag = "R1";

  // behavioural reference state
  bit [31:0] m_stat, m_en;
  bit [1:0]  m_code;

  always #10 clk = ~clk;

  sdmmc_irq_ctrl dut (.*);

  function automatic bit [31:0] sticky_set();
    bit [31:0] s = '0;
    s[31:24] = 8'hFF;
    for (int b = 11; b <= 14; b++) s[b] = 1'b1;
    s[5] = 1; s[3] = 1; s[2] = 1; s[1] = 1; s[0] = 1;
    return s;
  endfunction

  function automatic bit [31:0] exp_view();
    return m_stat | (32'(m_code) << 9) | (32'(card_clk_on) << 8)
           | (32'(buf_rd_rdy) << 7) | (32'(buf_wr_rdy) << 6);
  endfunction

  function automatic bit exp_irq();
    return (m_stat[11] & m_en[0]) | (m_stat[12] & m_en[1]) | (m_stat[13] & m_en[2])
         | (buf_wr_rdy & m_en[3]) | (buf_rd_rdy & m_en[4]) | (m_stat[14] & m_en[13])
         | (m_stat[30] & m_en[14]) | (m_stat[31] & m_en[15]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_en = '0; m_code = '0;
    end else begin
      bit [31:0] ev, cl;
      ev = evt_pulse & sticky_set();
      cl = (reg_sel && reg_wr && !reg_addr) ? (reg_wdata & sticky_set()) : '0;
      if (ev[2]) m_code = wcrc_code;
      else if (cl[2]) m_code = 2'd0;
      m_stat = (m_stat & ~cl) | ev;
      if (reg_sel && reg_wr && reg_addr) begin
        m_en = '0;
        for (int b = 0; b <= 4; b++)   m_en[b] = reg_wdata[b];
        for (int b = 12; b <= 18; b++) m_en[b] = reg_wdata[b];
      end
    end
  end

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  // compare all outputs against the model (called away from the edge)
  task automatic compare();
    check({cur_tag, " rdata"}, reg_rdata, reg_addr ? m_en : exp_view());
    check({cur_tag, " irq"}, 32'(irq), 32'(exp_irq()));
    check({cur_tag, " err_any R7"}, 32'(err_any), 32'(|(m_stat & 32'h2F)));
  endtask

  // one cycle: inputs held through the next edge, then checked at negedge
  task automatic cyc(bit sel, bit wr, bit addr, bit [31:0] wd, bit [31:0] ev);
    reg_sel = sel; reg_wr = wr; reg_addr = addr; reg_wdata = wd; evt_pulse = ev;
    @(negedge clk);
    reg_sel = 0; reg_wr = 0; evt_pulse = '0;
    compare();
  endtask

  task automatic rd(bit addr);
    reg_addr = addr; #1; compare();
  endtask

  initial begin
    #2000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1";
    rd(0); check("R1 status", reg_rdata, 32'h0);
    rd(1); check("R1 enable", reg_rdata, 32'h0);

    cur_tag = "R2";
    cyc(0, 0, 0, 0, 32'hFF00_782F);
    rd(0); check("R2 all sticky", reg_rdata & 32'hFF00_782F, 32'hFF00_782F);
    cyc(0, 0, 0, 0, 0);
    check("R2 held", reg_rdata & 32'hFF00_782F, 32'hFF00_782F);

    cur_tag = "R3";
    cyc(1, 1, 0, 32'hAA00_500A, 0);
    check("R3 partial clear", reg_rdata & 32'hFF00_782F, 32'h5500_2825);
    cyc(1, 1, 0, 32'h00FF_87D0, 0);
    check("R3 no effect", reg_rdata & 32'hFF00_782F, 32'h5500_2825);
    cyc(1, 1, 0, 32'hFFFF_FFFF, 0);
    check("R3 clear all", reg_rdata, 32'h0);

    cur_tag = "R11";
    cyc(0, 0, 0, 0, 32'h00FF_87D0);
    check("R11 ignored", reg_rdata, 32'h0);

    cur_tag = "R4";
    cyc(1, 1, 0, 32'h8000_0801, 32'h8000_0001);
    check("R4 event wins", reg_rdata, 32'h8000_0001);
    cyc(1, 1, 0, 32'h8000_0001, 0);
    check("R4 then clears", reg_rdata, 32'h0);

    cur_tag = "R5";
    card_clk_on = 1; buf_rd_rdy = 1; #1;
    check("R5 live", reg_rdata, 32'h0000_0180);
    buf_wr_rdy = 1; card_clk_on = 0; buf_rd_rdy = 0;
    cyc(1, 1, 0, 32'h0000_01C0, 0);
    check("R5 live write ignored", reg_rdata, 32'h0000_0040);
    buf_wr_rdy = 0;

    cur_tag = "R6";
    wcrc_code = 2'd2;
    cyc(0, 0, 0, 0, 32'h4);
    check("R6 no-token code", reg_rdata, 32'h0000_0404);
    check("R6 err", 32'(err_any), 1);
    wcrc_code = 2'd1;
    cyc(1, 1, 0, 32'h4, 32'h4);
    check("R6 reload on race", reg_rdata, 32'h0000_0204);
    cyc(1, 1, 0, 32'h600, 0);
    check("R6 code bits not writable", reg_rdata, 32'h0000_0204);
    cyc(1, 1, 0, 32'h4, 0);
    check("R6 cleared with bit 2", reg_rdata, 32'h0);

    cur_tag = "R7";
    for (int b = 0; b < 6; b++) begin
      cyc(0, 0, 0, 0, 32'(1) << b);
      check("R7 err per bit", 32'(err_any), 32'((32'h2F >> b) & 1));
      cyc(1, 1, 0, 32'hFFFF_FFFF, 0);
    end

    cur_tag = "R8";
    cyc(1, 1, 1, 32'hFFFF_FFFF, 0);
    check("R8 enable mask", reg_rdata, 32'h0007_F01F);
    cyc(1, 0, 1, 32'h0, 0);
    check("R8 read keeps", reg_rdata, 32'h0007_F01F);
    cyc(1, 1, 0, 32'hFFFF_FFFF, 0);
    rd(1); check("R8 status write keeps enable", reg_rdata, 32'h0007_F01F);

    cur_tag = "R10";
    cyc(1, 1, 1, 32'h0007_1000, 0);
    buf_rd_rdy = 1; buf_wr_rdy = 1;
    cyc(0, 0, 0, 0, 32'hFFFF_FFFF);
    check("R10 stored-only no irq", 32'(irq), 0);
    buf_rd_rdy = 0; buf_wr_rdy = 0;
    cyc(1, 1, 0, 32'hFFFF_FFFF, 0);

    cur_tag = "R9";
    begin
      int src [8] = '{11, 12, 13, 6, 7, 14, 30, 31};
      int enb [8] = '{0, 1, 2, 3, 4, 13, 14, 15};
      for (int k = 0; k < 8; k++) begin
        cyc(1, 1, 1, 32'(1) << enb[k], 0);
        check("R9 idle", 32'(irq), 0);
        if (src[k] == 6) buf_wr_rdy = 1;
        else if (src[k] == 7) buf_rd_rdy = 1;
        cyc(0, 0, 0, 0, (src[k] > 7) ? (32'(1) << src[k]) : 32'h0);
        check("R9 source raises irq", 32'(irq), 1);
        cyc(1, 1, 1, ~(32'(1) << enb[k]), 0);
        check("R9 other enables quiet", 32'(irq), 0);
        buf_wr_rdy = 0; buf_rd_rdy = 0;
        cyc(1, 1, 0, 32'hFFFF_FFFF, 0);
      end
    end

    cur_tag = "R1";
    rst_n = 0;
    cyc(0, 0, 0, 0, 32'hFFFF_FFFF);
    rst_n = 1;
    rd(0); check("R1 re-reset status", reg_rdata, 32'h0);
    rd(1); check("R1 re-reset enable", reg_rdata, 32'h0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule